// File: doc/BRIEF.md
# Video Sync Reference Validator

This block watches a standard-definition sync reference made of a line pulse, a frame pulse and an optional field-identity pulse. All three are sampled on the system clock. It measures the line period in clocks and the number of lines between frame pulses. It checks both the line period and the frame period against configurable windows. Once two back-to-back frames agree with each other, it declares the reference good. At that moment it looks the measurement up in a small parameter-defined table of formats. Then it drives an active-high loss flag low and reports the 6-bit code of the recognised format, or zero when no enabled entry fits.

Configuration arrives on plain level inputs that a host register would drive:
- a bypass bit that suppresses the window checks for high-definition references;
- a per-entry disable mask;
- a selector that decides which entry is reported when several entries have identical timing.

While the block is locked, only the line pulse is watched. Frame and field pulses can disappear without effect, and configuration changes do not alter the latched code. When the line pulse stops for a timeout, the block drops back to measuring.

The block has no data stream, so it has no valid/ready handshake. Every input is a level or a pulse that is sampled each clock. Every output is a level that is valid on every cycle.

Top module: `vsv_ref_validator`

## Requirements
- R1: After reset, ref_lost_o is 1, std_code_o is 0 and status_o is 8'h01.
- R2: Without bypass, a frame counts as good only if every measured line period lies inside [H_MIN, H_MAX] clocks, both ends included. A frame with any line period outside that range never leads to lock.
- R3: Without bypass, a frame counts as good only if the clock count between consecutive frame-pulse rising edges lies inside [V_MIN, V_MAX]. A frame period outside that range never leads to lock.
- R4: Lock needs two consecutive good frames that agree with each other. Their line counts must differ by at most LINE_TOL, their last line periods by at most HPER_TOL, and their field-pulse presence must be equal. The loss flag stays high until the frame-pulse edge that closes the second such frame, and it is low shortly after that edge.
- R5: At lock, the block reports the code of the lowest-index table entry that meets all of these conditions: it is not disabled (cfg_std_disable[i]=1 disables entry i); its line period is within HPER_TOL; its line count is within LINE_TOL; its field-pulse flag equals the observed presence. If no entry qualifies, the code is 0 while lock and a low loss flag still hold.
- R6: An entry marked ambiguous is a candidate only when cfg_amb_sel at its selector bit equals its selector value. In the default table, entries 0 (code 1) and 2 (code 3) share timing. Entry 0 is chosen when cfg_amb_sel[0]=0 and entry 2 when it is 1.
- R7: The field pulse is not needed for lock. A reference without field pulses locks, and field-pulse presence only steers which entry matches.
- R8: While locked, loss of the frame and field pulses and any change to cfg_std_disable or cfg_amb_sel leave std_code_o and ref_lost_o unchanged.
- R9: When no line-pulse rising edge arrives for LOSS_CLKS clocks, the block unlocks, sets ref_lost_o to 1 and clears std_code_o to 0.
- R10: With cfg_hd_bypass=1, no window check is applied. ref_lost_o is 0 exactly while a line-pulse edge has been seen within the last LOSS_CLKS clocks.
- R11: status_o bit 0 mirrors ref_lost_o, bit 1 is 1 while locked, and bits 7:2 are 0.
- R12: The period counters saturate at their maximum, so a stalled pulse reads as out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Line sync pulse, active high |
| vsync_i | input | 1 | Frame sync pulse, active high |
| fsync_i | input | 1 | Optional field-identity pulse, active high |
| cfg_hd_bypass | input | 1 | Skip window checks; loss flag follows line activity |
| cfg_std_disable | input | NSTD | Per-entry disable mask, 1 = excluded |
| cfg_amb_sel | input | AMB_W | Chooser among entries with identical timing |
| ref_lost_o | output | 1 | Reference-lost flag, active high |
| std_code_o | output | 6 | Recognised format code, 0 when none |
| status_o | output | 8 | Bit 0 loss flag, bit 1 locked, rest 0 |

## Verification
Each pulse input passes two sampling registers before it reaches the state machine. Lock, unlock and code updates therefore take effect on the second rising clock edge after the input edge that causes them. Loss of the line pulse is reported LOSS_CLKS plus about two clocks after the last line edge. The bench drives inputs and samples outputs on falling edges. Lock results are read only once the whole closing frame has been played out, and the no-lock check is read before the next frame pulse. Loss results are read after more than twice LOSS_CLKS, so no check lands near a transition.

// File: rtl/vsv_pkg.sv
package vsv_pkg;

  typedef enum logic [0:0] {
    VSV_HUNT = 1'b0,
    VSV_LOCK = 1'b1
  } vsv_state_e;

  // distance between two unsigned counts
  function automatic int unsigned vsv_absdiff(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/vsv_edge_sense.sv
module vsv_edge_sense #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] stage1_q, stage2_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[g] <= 1'b0;
        stage2_q[g] <= 1'b0;
      end else begin
        stage1_q[g] <= pin_i[g];
        stage2_q[g] <= stage1_q[g];
      end
    end
    assign rise_o[g] = stage1_q[g] & ~stage2_q[g];
  end
endmodule

// File: rtl/vsv_period_meter.sv
module vsv_period_meter #(
  parameter int SAT = 1024,
  parameter int W   = $clog2(SAT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_i,
  output logic         seen_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT_V = W'(SAT);

  logic [W-1:0] cnt_q;
  logic         seen_q;

  // count restarts at 1 on an edge, so at the next edge it equals the period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q  <= W'(1);
      seen_q <= 1'b1;
    end else if (cnt_q != SAT_V) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign seen_o = seen_q;
endmodule

// File: rtl/vsv_std_match.sv
module vsv_std_match #(
  parameter int NSTD     = 4,
  parameter int AMB_W    = 1,
  parameter int AMB_IW   = 1,
  parameter int HW       = 12,
  parameter int LW       = 10,
  parameter int HPER_TOL = 2,
  parameter int LINE_TOL = 1,
  parameter logic [NSTD*16-1:0]     STD_HPER    = '0,
  parameter logic [NSTD*16-1:0]     STD_LINES   = '0,
  parameter logic [NSTD-1:0]        STD_FSYNC   = '0,
  parameter logic [NSTD*6-1:0]      STD_CODE    = '0,
  parameter logic [NSTD-1:0]        STD_AMB_EN  = '0,
  parameter logic [NSTD-1:0]        STD_AMB_VAL = '0,
  parameter logic [NSTD*AMB_IW-1:0] STD_AMB_BIT = '0
) (
  input  logic [HW-1:0]    hper_i,
  input  logic [LW-1:0]    lines_i,
  input  logic             fsync_i,
  input  logic [NSTD-1:0]  dis_i,
  input  logic [AMB_W-1:0] amb_i,
  output logic             hit_o,
  output logic [5:0]       code_o
);
  import vsv_pkg::*;

  logic [NSTD-1:0] cand;

  for (genvar i = 0; i < NSTD; i++) begin : g_ent
    localparam int unsigned TH = int'(STD_HPER[i*16 +: 16]);
    localparam int unsigned TL = int'(STD_LINES[i*16 +: 16]);
    logic amb_ok;
    assign amb_ok  = !STD_AMB_EN[i] ||
                     (amb_i[STD_AMB_BIT[i*AMB_IW +: AMB_IW]] == STD_AMB_VAL[i]);
    assign cand[i] = (vsv_absdiff(32'(hper_i), TH) <= HPER_TOL) &&
                     (vsv_absdiff(32'(lines_i), TL) <= LINE_TOL) &&
                     (fsync_i == STD_FSYNC[i]) && !dis_i[i] && amb_ok;
  end

  // lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    code_o = 6'd0;
    for (int i = NSTD - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o  = 1'b1;
        code_o = STD_CODE[i*6 +: 6];
      end
    end
  end
endmodule

// File: rtl/vsv_ref_validator.sv
module vsv_ref_validator #(
  parameter int H_MIN     = 801,
  parameter int H_MAX     = 1890,
  parameter int V_MIN     = 432000,
  parameter int V_MAX     = 675000,
  parameter int LOSS_CLKS = 2048,
  parameter int HPER_TOL  = 2,
  parameter int LINE_TOL  = 1,
  parameter int NSTD      = 4,
  parameter int AMB_W     = 1,
  parameter int AMB_IW    = (AMB_W > 1) ? $clog2(AMB_W) : 1,
  parameter logic [NSTD*16-1:0]     STD_HPER    = {16'd858, 16'd1716, 16'd1728, 16'd1716},
  parameter logic [NSTD*16-1:0]     STD_LINES   = {16'd525, 16'd262, 16'd312, 16'd262},
  parameter logic [NSTD-1:0]        STD_FSYNC   = 4'b0111,
  parameter logic [NSTD*6-1:0]      STD_CODE    = {6'h04, 6'h03, 6'h02, 6'h01},
  parameter logic [NSTD-1:0]        STD_AMB_EN  = 4'b0101,
  parameter logic [NSTD-1:0]        STD_AMB_VAL = 4'b0100,
  parameter logic [NSTD*AMB_IW-1:0] STD_AMB_BIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             fsync_i,
  input  logic             cfg_hd_bypass,
  input  logic [NSTD-1:0]  cfg_std_disable,
  input  logic [AMB_W-1:0] cfg_amb_sel,
  output logic             ref_lost_o,
  output logic [5:0]       std_code_o,
  output logic [7:0]       status_o
);
  import vsv_pkg::*;

  localparam int HSAT = ((H_MAX > LOSS_CLKS) ? H_MAX : LOSS_CLKS) + 1;
  localparam int HW   = $clog2(HSAT + 1);
  localparam int VSAT = V_MAX + 1;
  localparam int VW   = $clog2(VSAT + 1);
  localparam int LMAX = V_MAX / H_MIN + 2;
  localparam int LW   = $clog2(LMAX + 1);
  localparam logic [LW-1:0] LMAX_V = LW'(LMAX);

  // edge detection
  logic [2:0] rises;
  logic h_rise, v_rise, f_rise;

  vsv_edge_sense #(.N(3)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .pin_i({fsync_i, vsync_i, hsync_i}),
    .rise_o(rises)
  );
  assign h_rise = rises[0];
  assign v_rise = rises[1];
  assign f_rise = rises[2];

  // period counters
  logic          h_seen, v_seen;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;

  vsv_period_meter #(.SAT(HSAT), .W(HW)) u_hmeter (
    .clk(clk), .rst_n(rst_n), .edge_i(h_rise), .seen_o(h_seen), .cnt_o(h_cnt)
  );
  vsv_period_meter #(.SAT(VSAT), .W(VW)) u_vmeter (
    .clk(clk), .rst_n(rst_n), .edge_i(v_rise), .seen_o(v_seen), .cnt_o(v_cnt)
  );

  // state
  vsv_state_e    state_q;
  logic [LW-1:0] lcnt_q, prev_lines_q;
  logic [HW-1:0] hper_q, prev_hper_q;
  logic          fseen_q, hok_q, prev_f_q, prev_ok_q;
  logic [5:0]    code_q;

  // frame record evaluated in the frame-edge cycle
  logic          h_idle, h_meas, h_in_win, hok_now, f_now;
  logic          v_meas, v_in_win, hper_win, rec_ok, consistent, locked;
  logic [HW-1:0] hper_now;
  logic [LW-1:0] lines_now;
  logic          match_hit;
  logic [5:0]    match_code;

  assign locked    = (state_q == VSV_LOCK);
  assign h_idle    = !h_seen || (32'(h_cnt) >= LOSS_CLKS);
  assign h_meas    = h_rise && h_seen;
  assign h_in_win  = (32'(h_cnt) >= H_MIN) && (32'(h_cnt) <= H_MAX);
  assign hper_now  = h_meas ? h_cnt : hper_q;
  assign hok_now   = hok_q && !(h_meas && !h_in_win);
  assign hper_win  = (32'(hper_now) >= H_MIN) && (32'(hper_now) <= H_MAX);
  assign lines_now = lcnt_q;
  assign f_now     = fseen_q || f_rise;
  assign v_meas    = v_rise && v_seen;
  assign v_in_win  = (32'(v_cnt) >= V_MIN) && (32'(v_cnt) <= V_MAX);
  assign rec_ok    = v_meas && (lines_now != '0) &&
                     (cfg_hd_bypass || (v_in_win && hok_now && hper_win));
  assign consistent = prev_ok_q &&
                      (vsv_absdiff(32'(lines_now), 32'(prev_lines_q)) <= LINE_TOL) &&
                      (vsv_absdiff(32'(hper_now), 32'(prev_hper_q)) <= HPER_TOL) &&
                      (prev_f_q == f_now);

  vsv_std_match #(
    .NSTD(NSTD), .AMB_W(AMB_W), .AMB_IW(AMB_IW), .HW(HW), .LW(LW),
    .HPER_TOL(HPER_TOL), .LINE_TOL(LINE_TOL),
    .STD_HPER(STD_HPER), .STD_LINES(STD_LINES), .STD_FSYNC(STD_FSYNC),
    .STD_CODE(STD_CODE), .STD_AMB_EN(STD_AMB_EN), .STD_AMB_VAL(STD_AMB_VAL),
    .STD_AMB_BIT(STD_AMB_BIT)
  ) u_match (
    .hper_i(hper_now), .lines_i(lines_now), .fsync_i(f_now),
    .dis_i(cfg_std_disable), .amb_i(cfg_amb_sel),
    .hit_o(match_hit), .code_o(match_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= VSV_HUNT;
      lcnt_q       <= '0;
      hper_q       <= '0;
      fseen_q      <= 1'b0;
      hok_q        <= 1'b1;
      prev_lines_q <= '0;
      prev_hper_q  <= '0;
      prev_f_q     <= 1'b0;
      prev_ok_q    <= 1'b0;
      code_q       <= 6'd0;
    end else begin
      if (h_meas) hper_q <= h_cnt;
      if (state_q == VSV_LOCK) begin
        // frame and field pulses are not watched here
        if (h_idle) begin
          state_q   <= VSV_HUNT;
          code_q    <= 6'd0;
          prev_ok_q <= 1'b0;
          lcnt_q    <= '0;
          fseen_q   <= 1'b0;
          hok_q     <= 1'b1;
        end
      end else begin
        if (v_rise) begin
          lcnt_q  <= h_rise ? LW'(1) : '0;
          fseen_q <= 1'b0;
          hok_q   <= 1'b1;
        end else begin
          if (h_rise && (lcnt_q != LMAX_V)) lcnt_q <= lcnt_q + LW'(1);
          fseen_q <= f_now;
          hok_q   <= hok_now;
        end
        if (h_idle) begin
          prev_ok_q <= 1'b0;
        end else if (v_meas) begin
          if (rec_ok && consistent) begin
            state_q   <= VSV_LOCK;
            code_q    <= match_hit ? match_code : 6'd0;
            prev_ok_q <= 1'b0;
          end else begin
            prev_lines_q <= lines_now;
            prev_hper_q  <= hper_now;
            prev_f_q     <= f_now;
            prev_ok_q    <= rec_ok;
          end
        end
      end
    end
  end

  assign ref_lost_o = cfg_hd_bypass ? h_idle : !locked;
  assign std_code_o = code_q;
  assign status_o   = {6'd0, locked, ref_lost_o};
endmodule

// File: rtl/vsv_ref_checker.sv
module vsv_ref_checker #(
  parameter int HSAT = 2049,
  parameter int HW   = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          locked,
  input logic          v_rise,
  input logic          h_idle,
  input logic [5:0]    std_code,
  input logic [HW-1:0] h_cnt
);
  // R12
  h_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(h_cnt) <= HSAT);

  // R4
  lock_on_frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(v_rise));

  // R9
  unlock_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(h_idle));

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locked) && locked) |-> $stable(std_code));

  // R5
  code_zero_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (std_code == 6'd0));
endmodule

bind vsv_ref_validator vsv_ref_checker #(.HSAT(HSAT), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .v_rise(v_rise),
  .h_idle(h_idle), .std_code(std_code_o), .h_cnt(h_cnt)
);

// File: tb/vsv_ref_validator_bench.sv
module vsv_ref_validator_bench;
  localparam int LOSS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 0, vs = 0, fs = 0, byp = 0;
  logic [3:0] dis = 4'h0;
  logic [0:0] amb = 1'b0;
  logic lost;
  logic [5:0] code;
  logic [7:0] stat;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vsv_ref_validator #(
    .H_MIN(20), .H_MAX(60), .V_MIN(400), .V_MAX(1200), .LOSS_CLKS(LOSS),
    .HPER_TOL(2), .LINE_TOL(1), .NSTD(4), .AMB_W(1),
    .STD_HPER({16'd30, 16'd40, 16'd50, 16'd40}),
    .STD_LINES({16'd20, 16'd20, 16'd16, 16'd20}),
    .STD_FSYNC(4'b0111),
    .STD_CODE({6'h04, 6'h03, 6'h02, 6'h01}),
    .STD_AMB_EN(4'b0101), .STD_AMB_VAL(4'b0100), .STD_AMB_BIT(4'b0000)
  ) u_vsv_ref_validator (
    .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs), .fsync_i(fs),
    .cfg_hd_bypass(byp), .cfg_std_disable(dis), .cfg_amb_sel(amb),
    .ref_lost_o(lost), .std_code_o(code), .status_o(stat)
  );

  // bench copy of the table as stated in R5/R6
  int TH[4]  = '{40, 50, 40, 30};
  int TL[4]  = '{20, 16, 20, 20};
  int TF[4]  = '{1, 1, 1, 0};
  int TC[4]  = '{1, 2, 3, 4};
  int TAE[4] = '{1, 0, 1, 0};
  int TAV[4] = '{0, 0, 1, 0};

  function automatic int exp_code(int hp, int ln, int f, int a, int m);
    for (int i = 0; i < 4; i++) begin
      int dh, dl;
      dh = (hp > TH[i]) ? hp - TH[i] : TH[i] - hp;
      dl = (ln > TL[i]) ? ln - TL[i] : TL[i] - ln;
      if (dh <= 2 && dl <= 1 && f == TF[i] && ((m >> i) & 1) == 0 &&
          (TAE[i] == 0 || a == TAV[i]))
        return TC[i];
    end
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frames(int hp, int ln, int n, bit fon, bit von);
    for (int f = 0; f < n; f++)
      for (int l = 0; l < ln; l++)
        for (int c = 0; c < hp; c++) begin
          @(negedge clk);
          hs = (c < 4);
          vs = von && (l == 0) && (c < 4);
          fs = fon && (l == 1) && (c < 4);
        end
    @(negedge clk);
    hs = 0; vs = 0; fs = 0;
  endtask

  task automatic idle_out();
    repeat (3 * LOSS) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int fh[4] = '{40, 50, 30, 45};
    int fl[4] = '{20, 16, 20, 18};
    int ff[4] = '{1, 1, 0, 1};
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lost", lost, 1);
    chk("R1 code", code, 0);
    chk("R1 status", stat, 8'h01);

    // R5 R6 R7 R4 R9 R11 sweep: format x selector x disable of relevant entry
    for (int fi = 0; fi < 4; fi++)
      for (int a = 0; a < 2; a++)
        for (int d = 0; d < 2; d++) begin
          int rel, m, e;
          rel = (fi == 0) ? (a ? 2 : 0) : (fi == 1) ? 1 : (fi == 2) ? 3 : 0;
          m = d ? (1 << rel) : (~(1 << rel)) & 4'hF;
          amb = a[0]; dis = m[3:0];
          e = exp_code(fh[fi], fl[fi], ff[fi], a, m);
          frames(fh[fi], fl[fi], 2, ff[fi][0], 1'b1);
          chk("R4 lost before second good frame closes", lost, 1);
          frames(fh[fi], fl[fi], 1, ff[fi][0], 1'b1);
          chk("R4 lost after lock", lost, 0);
          chk("R5 R6 R7 code", code, e);
          chk("R11 status locked", stat, 8'h02);
          idle_out();
          chk("R9 lost after idle", lost, 1);
          chk("R9 code cleared", code, 0);
        end
    amb = 0; dis = 0;

    // R7 field pulse presence steers match: 30/20 with field pulse has no entry
    frames(30, 20, 3, 1'b1, 1'b1);
    chk("R7 locked without table match", stat, 8'h02);
    chk("R7 code", code, 0);
    idle_out();

    // R2 line period outside window on both sides
    frames(15, 50, 4, 1'b1, 1'b1);
    chk("R2 short line", lost, 1);
    idle_out();
    frames(70, 12, 4, 1'b1, 1'b1);
    chk("R2 long line", lost, 1);
    idle_out();
    // R2 boundary: line period exactly H_MAX locks
    frames(60, 15, 3, 1'b1, 1'b1);
    chk("R2 at H_MAX", lost, 0);
    idle_out();

    // R3 frame period outside window
    frames(40, 8, 4, 1'b1, 1'b1);
    chk("R3 short frame", lost, 1);
    idle_out();
    frames(40, 32, 4, 1'b1, 1'b1);
    chk("R3 long frame", lost, 1);
    idle_out();

    // R4 alternating line counts never agree
    for (int k = 0; k < 3; k++) begin
      frames(40, 20, 1, 1'b1, 1'b1);
      frames(40, 24, 1, 1'b1, 1'b1);
    end
    chk("R4 inconsistent frames", lost, 1);
    idle_out();

    // R8 locked: drop frame/field pulses and change configuration
    frames(40, 20, 3, 1'b1, 1'b1);
    chk("R8 locked code", code, 1);
    dis = 4'hF; amb = 1'b1;
    frames(40, 60, 1, 1'b0, 1'b0);
    chk("R8 code held", code, 1);
    chk("R8 lost held", lost, 0);
    idle_out();
    chk("R9 unlock after pulses stop", stat, 8'h01);
    dis = 0; amb = 0;

    // R10 bypass: activity alone clears the flag, windows skipped
    byp = 1;
    frames(15, 50, 1, 1'b1, 1'b1);
    chk("R10 lost low with activity", lost, 0);
    frames(15, 50, 2, 1'b1, 1'b1);
    chk("R10 locked out of window", stat, 8'h02);
    chk("R10 code", code, 0);
    idle_out();
    chk("R10 lost after idle", lost, 1);
    byp = 0;

    finish_run();
  end
endmodule